// File: doc/BRIEF.md
# DRAM Refresh Interval Rescaler

This block recomputes the auto-refresh interval count of a DRAM controller channel when that channel's memory clock is about to change. During initialisation, software or a sequencer presents, for each channel, the clock frequency the channel runs at now (in Hz) and the refresh count currently programmed. The block keeps that count multiplied by 1000, together with the frequency, as the channel's baseline.

Later a rescale request names a channel and a new clock frequency in kHz. The block first divides the baseline frequency by the requested frequency to get a truncated ratio. It then divides the scaled baseline count by that ratio to get the new count. Both divisions run on bit-serial restoring dividers. The block writes the result to the refresh-count register of the selected channel with a single-cycle write strobe. Requests that name a missing channel, ask for 0 kHz, or produce a zero ratio raise an error pulse and write nothing.

With a 200 MHz baseline and a count of 0x618 (a 7.8 µs period), the block yields about 0x287 at 83 MHz, 0x30C at 100 MHz and 0x618 at 200 MHz.

Top module: `refresh_rescaler`

## Requirements
- R1: Two channels, numbered 0 and 1, each hold their own baseline. A capture strobe with a valid channel stores the presented frequency in Hz and the presented count multiplied by 1000 for that channel only.
- R2: For an accepted request, the ratio is the stored frequency in Hz divided by the requested frequency in kHz, truncated toward zero.
- R3: The written count is the stored scaled count divided by the ratio, truncated, and appears on `wr_data` zero-extended.
- R4: The write address is the channel number times 0x10000 plus 0x30: 0x00030 for channel 0 and 0x10030 for channel 1.
- R5: A request or capture naming channel 2 or 3 raises `err` for exactly one cycle, in the cycle after the strobe. It produces no write and leaves both baselines unchanged.
- R6: A request for 0 kHz, or one whose ratio comes out as zero, raises `err` for one cycle and produces no write; no division by zero takes place.
- R7: `busy` is high from the cycle after a request is accepted up to and including the single cycle in which `wr_en` is high, and is low in the cycle after it.
- R8: A request presented while `busy` is high is ignored. No second write results from it.
- R9: When a capture and a request for the same channel arrive in the same cycle, the request uses the baseline held before that cycle. The new baseline applies to later requests.
- R10: While reset is held and right after it, `busy`, `err` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_valid | input | 1 | Capture strobe for a baseline |
| cap_chan | input | 2 | Channel the capture targets |
| cap_freq_hz | input | 32 | Present channel clock in Hz |
| cap_count | input | 16 | Refresh count programmed now |
| req_valid | input | 1 | Rescale request strobe |
| req_chan | input | 2 | Channel to rescale |
| req_khz | input | 32 | New channel clock in kHz |
| busy | output | 1 | Rescale in progress |
| err | output | 1 | One-cycle error pulse |
| wr_en | output | 1 | Refresh register write strobe |
| wr_addr | output | 32 | Refresh register byte address |
| wr_data | output | 32 | New refresh count |

## Verification
The two functions that can meet in one cycle are baseline capture and request acceptance on the same channel. The bench drives both strobes in a single cycle, with a new frequency and count, and expects the written count to be computed from the old baseline. A following request must then give the value that the new baseline implies. A second overlap, a request arriving while a rescale is still running, is provoked mid-division and judged by counting write strobes and checking the address and data of the only one.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned SCALE = 1000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV1 = 2'd1,
    ST_DIV2 = 2'd2,
    ST_WRITE = 2'd3
  } rr_state_e;
endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/rr_divider.sv
module rr_divider #(
  parameter int DW = 32,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quotient
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo_q, quo_d;
  logic [VW:0]   rem_q, rem_d;
  logic [VW-1:0] dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [VW:0]   rem_sh;
  logic          fits;

  always_comb begin
    rem_sh = {rem_q[VW-1:0], quo_q[DW-1]};
    fits   = (rem_sh >= {1'b0, dvs_q});
    quo_d  = quo_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start) begin
      quo_d = dividend;
      rem_d = '0;
      dvs_d = divisor;
      cnt_d = CW'(DW);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
      quo_d = {quo_q[DW-2:0], fits};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start || run_q) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
        dvs_q <= dvs_d;
        cnt_q <= cnt_d;
      end
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_DIV_RUN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0)); // R3
  AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !run_q); // R3
endmodule

// File: rtl/rr_baseline.sv
module rr_baseline
  import rr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 2,
  parameter int FREQ_W = 32,
  parameter int CNT_W  = 16,
  parameter int SC_W   = CNT_W + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [CH_W-1:0]   cap_chan,
  input  logic [FREQ_W-1:0] cap_freq,
  input  logic [CNT_W-1:0]  cap_count,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [FREQ_W-1:0] rd_freq,
  output logic [SC_W-1:0]   rd_scaled,
  output logic              cap_bad
);
  logic [FREQ_W-1:0] freq_q   [NUM_CH];
  logic [SC_W-1:0]   scaled_q [NUM_CH];
  logic [SC_W-1:0]   cap_scaled;

  assign cap_scaled = SC_W'(cap_count) * SC_W'(SCALE);
  assign cap_bad    = cap_valid && !(int'(cap_chan) < NUM_CH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
    logic load;
    assign load = cap_valid && (cap_chan == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freq_q[g]   <= '0;
        scaled_q[g] <= '0;
      end else if (load) begin
        freq_q[g]   <= cap_freq;
        scaled_q[g] <= cap_scaled;
      end
    end

    AST_CAP_BAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_bad |=> $stable(freq_q[g]) && $stable(scaled_q[g])); // R5
  end

  always_comb begin
    rd_freq   = '0;
    rd_scaled = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_chan == CH_W'(i)) begin
        rd_freq   = freq_q[i];
        rd_scaled = scaled_q[i];
      end
    end
  end
endmodule

// File: rtl/refresh_rescaler.sv
module refresh_rescaler
  import rr_pkg::*;
#(
  parameter int          NUM_CH   = 2,
  parameter int          CH_W     = 2,
  parameter int          FREQ_W   = 32,
  parameter int          CNT_W    = 16,
  parameter int          REG_W    = 32,
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] WIN_SPAN = 32'h0001_0000,
  parameter logic [31:0] REG_OFS  = 32'h0000_0030
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  input  logic [CH_W-1:0]   cap_chan,
  input  logic [FREQ_W-1:0] cap_freq_hz,
  input  logic [CNT_W-1:0]  cap_count,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [FREQ_W-1:0] req_khz,
  output logic              busy,
  output logic              err,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data
);
  localparam int SC_W = CNT_W + 10;

  logic rst_s;

  rr_state_e         state_q, state_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [SC_W-1:0]   scaled_q, scaled_d;
  logic [SC_W-1:0]   result_q, result_d;
  logic              err_q, err_d;

  logic [FREQ_W-1:0] base_freq;
  logic [SC_W-1:0]   base_scaled;
  logic              cap_bad;
  logic              idle, chan_ok, req_ok, req_bad;
  logic              d1_done, d2_done, d2_start;
  logic [FREQ_W-1:0] d1_quot;
  logic [SC_W-1:0]   d2_quot;

  rr_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  rr_baseline #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .FREQ_W (FREQ_W),
    .CNT_W  (CNT_W),
    .SC_W   (SC_W)
  ) u_base (
    .clk       (clk),
    .rst_n     (rst_s),
    .cap_valid (cap_valid),
    .cap_chan  (cap_chan),
    .cap_freq  (cap_freq_hz),
    .cap_count (cap_count),
    .rd_chan   (req_chan),
    .rd_freq   (base_freq),
    .rd_scaled (base_scaled),
    .cap_bad   (cap_bad)
  );

  assign idle    = (state_q == ST_IDLE);
  assign chan_ok = (int'(req_chan) < NUM_CH);
  assign req_ok  = req_valid && idle && chan_ok && (req_khz != '0);
  assign req_bad = req_valid && idle && !(chan_ok && (req_khz != '0));

  rr_divider #(.DW(FREQ_W), .VW(FREQ_W)) u_div_ratio (
    .clk      (clk),
    .rst_n    (rst_s),
    .start    (req_ok),
    .dividend (base_freq),
    .divisor  (req_khz),
    .done     (d1_done),
    .quotient (d1_quot)
  );

  rr_divider #(.DW(SC_W), .VW(FREQ_W)) u_div_count (
    .clk      (clk),
    .rst_n    (rst_s),
    .start    (d2_start),
    .dividend (scaled_q),
    .divisor  (d1_quot),
    .done     (d2_done),
    .quotient (d2_quot)
  );

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    scaled_d = scaled_q;
    result_d = result_q;
    err_d    = req_bad || cap_bad;
    d2_start = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_ok) begin
          chan_d   = req_chan;
          scaled_d = base_scaled;
          state_d  = ST_DIV1;
        end
      end
      ST_DIV1: begin
        if (d1_done) begin
          if (d1_quot == '0) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            d2_start = 1'b1;
            state_d  = ST_DIV2;
          end
        end
      end
      ST_DIV2: begin
        if (d2_done) begin
          result_d = d2_quot;
          state_d  = ST_WRITE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q  <= ST_IDLE;
      chan_q   <= '0;
      scaled_q <= '0;
      result_q <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (req_ok) begin
        chan_q   <= chan_d;
        scaled_q <= scaled_d;
      end
      if (d2_done) begin
        result_q <= result_d;
      end
    end
  end

  assign busy    = !idle;
  assign err     = err_q;
  assign wr_en   = (state_q == ST_WRITE);
  assign wr_data = REG_W'(result_q);
  assign wr_addr = ADDR_W'(chan_q) * ADDR_W'(WIN_SPAN) + ADDR_W'(REG_OFS);

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |=> !wr_en); // R7
  AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |-> busy); // R7
  AST_IDLE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |=> !busy); // R7
  AST_ERR_NO_WR: assert property (@(posedge clk) disable iff (!rst_s)
    err |-> !wr_en); // R5
  AST_WR_CHAN_OK: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |-> (int'(chan_q) < NUM_CH)); // R5
  AST_NO_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_s)
    d2_start |-> (d1_quot != '0)); // R6
  AST_BUSY_HOLDS_CHAN: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy)) |-> $stable(chan_q)); // R8
endmodule

// File: tb/tb_refresh_rescaler.sv
`timescale 1ns/1ps
module tb_refresh_rescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [1:0]  cap_chan = '0;
  logic [31:0] cap_freq_hz = '0;
  logic [15:0] cap_count = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_chan = '0;
  logic [31:0] req_khz = '0;
  logic        busy, err, wr_en;
  logic [31:0] wr_addr, wr_data;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;

  always #2.5 clk = ~clk;

  refresh_rescaler dut (
    .clk (clk), .rst_n (rst_n),
    .cap_valid (cap_valid), .cap_chan (cap_chan),
    .cap_freq_hz (cap_freq_hz), .cap_count (cap_count),
    .req_valid (req_valid), .req_chan (req_chan), .req_khz (req_khz),
    .busy (busy), .err (err), .wr_en (wr_en),
    .wr_addr (wr_addr), .wr_data (wr_data)
  );

  always @(posedge clk) if (wr_en) wr_cnt++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model(input longint f_hz, input longint cnt, input longint khz);
    longint ratio;
    if (khz == 0) return -1;
    ratio = f_hz / khz;
    if (ratio == 0) return -1;
    return (cnt * 1000) / ratio;
  endfunction

  task automatic capture(input int ch, input longint f_hz, input longint cnt);
    @(negedge clk);
    cap_valid = 1'b1; cap_chan = 2'(ch); cap_freq_hz = 32'(f_hz); cap_count = 16'(cnt);
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  // Waits for the outcome of an already accepted request and judges it.
  task automatic judge(input longint exp, input longint exp_addr, input int wr0, input string tag);
    bit seen = 0, errseen = 0, busy_ok = 1;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (wr_en) begin
        seen = 1;
        check(exp >= 0, {tag, " unexpected write"}, longint'(wr_data), exp);
        check(longint'(wr_data) == exp, {tag, " data"}, longint'(wr_data), exp);
        check(longint'(wr_addr) == exp_addr, {tag, " R4 addr"}, longint'(wr_addr), exp_addr);
      end else if (err) begin
        seen = 1; errseen = 1;
      end else if (!busy) begin
        busy_ok = 0;
      end
      if (!seen) @(negedge clk);
    end
    check(seen, {tag, " R7 no outcome"}, 0, 1);
    if (exp < 0) begin
      check(errseen, {tag, " err expected"}, errseen, 1);
      check(wr_cnt == wr0, {tag, " no write expected"}, wr_cnt - wr0, 0);
    end else begin
      check(busy_ok, {tag, " R7 busy low before strobe"}, busy_ok, 1);
    end
    @(negedge clk);
    check(!busy && !wr_en && !err, {tag, " R7 idle after"}, {busy, wr_en, err}, 0);
  endtask

  task automatic run_req(input int ch, input longint khz, input longint exp,
                         input longint exp_addr, input string tag);
    int wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 2'(ch); req_khz = 32'(khz);
    @(negedge clk);
    req_valid = 1'b0;
    judge(exp, exp_addr, wr0, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && !err && !wr_en, "R10 outputs in reset", {busy, err, wr_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !err && !wr_en, "R10 outputs after reset", {busy, err, wr_en}, 0);
  endtask

  task automatic t_sweep();
    longint khz_list[5] = '{83000, 100000, 133000, 166000, 200000};
    capture(0, 200000000, 'h618);
    capture(1, 133000000, 1037);
    foreach (khz_list[i])
      run_req(0, khz_list[i], model(200000000, 'h618, khz_list[i]), 'h30, "R1 R2 R3 ch0 sweep");
    check(model(200000000, 'h618, 83000) == 'h287, "R3 model 83MHz", model(200000000, 'h618, 83000), 'h287);
    run_req(1, 200000, model(133000000, 1037, 200000), 'h10030, "R1 R4 ch1");
  endtask

  task automatic t_bad_chan();
    int wr0;
    run_req(2, 100000, -1, 0, "R5 request chan2");
    wr0 = wr_cnt;
    @(negedge clk);
    cap_valid = 1'b1; cap_chan = 2'd3; cap_freq_hz = 32'd50000000; cap_count = 16'd7;
    @(negedge clk);
    cap_valid = 1'b0;
    check(err, "R5 capture chan3 err", err, 1);
    @(negedge clk);
    check(!err, "R5 err one cycle", err, 0);
    check(wr_cnt == wr0, "R5 capture no write", wr_cnt - wr0, 0);
    run_req(0, 200000, model(200000000, 'h618, 200000), 'h30, "R5 ch0 baseline kept");
    run_req(1, 200000, model(133000000, 1037, 200000), 'h10030, "R5 ch1 baseline kept");
  endtask

  task automatic t_zero();
    run_req(0, 0, -1, 0, "R6 zero kHz");
    run_req(0, 300000000, -1, 0, "R6 zero ratio");
  endtask

  task automatic t_busy_ignore();
    int wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 2'd0; req_khz = 32'd100000;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_chan = 2'd1; req_khz = 32'd200000;
    @(negedge clk);
    req_valid = 1'b0;
    judge(model(200000000, 'h618, 100000), 'h30, wr0, "R8 first request");
    repeat (100) @(negedge clk);
    check(wr_cnt == wr0 + 1, "R8 single write", wr_cnt - wr0, 1);
  endtask

  task automatic t_same_cycle();
    int wr0 = wr_cnt;
    @(negedge clk);
    cap_valid = 1'b1; cap_chan = 2'd0; cap_freq_hz = 32'd166000000; cap_count = 16'h500;
    req_valid = 1'b1; req_chan = 2'd0; req_khz = 32'd100000;
    @(negedge clk);
    cap_valid = 1'b0; req_valid = 1'b0;
    judge(model(200000000, 'h618, 100000), 'h30, wr0, "R9 old baseline");
    run_req(0, 100000, model(166000000, 'h500, 100000), 'h30, "R9 new baseline");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep();
    t_bad_chan();
    t_zero();
    t_busy_ignore();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule